// File: doc/BRIEF.md
# Configuration Access PIO Engine

This block lets host software perform one PCIe configuration read or write at a time through a small 32-bit register window. Software programs a transaction type, a 64-bit address, write data and a byte-enable mask, then sets a start bit. The engine copies the programmed fields and presents them as one request on a valid/ready request port. It then waits for a single completion on a response port, which carries read data and a three-bit completion code.

When the completion arrives, or when a programmable cycle budget runs out, the engine records the outcome. It keeps the completion code, a flag that marks the request as non-posted, and the read data. It also sets a write-1-to-clear interrupt status bit, which drives an interrupt output while its mask bit is clear. Software builds the configuration address itself and places the bus in bits 27:20, the device in bits 19:15, the function in bits 14:12 and the dword register offset in bits 11:2. For a write of `size` bytes at byte offset `o`, software shifts the data left by 8*o bits and sets the strobe to ((1<<size)-1)<<o. A read uses a strobe of 0xF. The engine forwards all of these unchanged.

Top module: `cfg_pio_engine`

## Requirements
- R1: After reset, these registers read zero: START (0x04), STATUS (0x08), READ DATA (0x1C) and IRQ STATUS (0x20). IRQ MASK (0x24) reads 1, and `req_valid` and `pio_irq` are low.
- R2: Writing a value with bit 0 set to START (0x04) while idle launches a request. In the cycle after that write, `req_valid` is high and carries the type from CONTROL (0x00) bits 3:0, the address {ADDR HIGH (0x10), ADDR LOW (0x0C)}, the data from WRITE DATA (0x14), the mask from STROBE (0x18) bits 3:0 and the window-bypass flag from CONTROL bit 24. START reads 1 until the request completes.
- R3: A write to START while a request is in flight neither launches a second request nor aborts the current one, whatever its value.
- R4: Writes to CONTROL, ADDR LOW, ADDR HIGH, WRITE DATA or STROBE during a request do not change the request fields that are being presented.
- R5: A response is accepted on the first clock edge after the request handshake at which `rsp_valid` is high. From the next cycle START reads 0 and STATUS bits 9:7 hold `rsp_status` (0 OK, 1 unsupported request, 2 configuration retry, 4 completer abort).
- R6: STATUS bit 0 is 1 when the finished request had a type of 0x8 to 0xB (configuration read type 0 or type 1, configuration write type 0 or type 1), and 0 for any other type code.
- R7: READ DATA takes `rsp_data` when the completion code is 0, and reads 0xFFFFFFFF after any other completion.
- R8: If no response is accepted within TIMEOUT (0x28) clock cycles of the launch, the engine completes at exactly that cycle with code 4 and READ DATA 0xFFFFFFFF. A value of 0 acts as 1.
- R9: Every completion sets IRQ STATUS bit 0. Writing 1 to that bit clears it, writing 0 has no effect, and a completion in the same cycle as a clear wins.
- R10: `pio_irq` is high exactly while IRQ STATUS bit 0 is 1 and IRQ MASK bit 0 is 0.
- R11: A response offered while the engine is idle, or before the request handshake, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 6 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data (combinational from host_addr) |
| req_valid | output | 1 | Request is presented |
| req_ready | input | 1 | Request accepted by the receiver |
| req_type | output | 4 | Transaction type code |
| req_addr | output | 64 | Request address |
| req_wdata | output | 32 | Write payload |
| req_strb | output | 4 | Byte enables |
| req_win_bypass | output | 1 | Skip address window translation |
| rsp_valid | input | 1 | Completion is presented |
| rsp_status | input | 3 | Completion code |
| rsp_data | input | 32 | Completion read data |
| pio_irq | output | 1 | Unmasked completion interrupt |

## Verification
The bench places the timeout exactly. It checks that START is still 1 one cycle before the budget runs out and 0 on the cycle it does, which catches a counter that is off by one either way. It rewrites the programmed fields and pokes START while a request is in flight, which exposes a design that forwards live registers or lets a second launch through. It offers responses while idle and before the handshake, and a design that accepted those would overwrite STATUS or raise the interrupt by mistake. Error completions must leave all-ones read data and a posted type must clear the non-posted flag, which catches a design that keeps stale data or hard-codes the flag.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned HOST_AW = 6;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_state_t;

  localparam logic [2:0] CPL_OK = 3'd0;
  localparam logic [2:0] CPL_CA = 3'd4;

  localparam logic [HOST_AW-1:0] OFF_CTRL   = 6'h00;
  localparam logic [HOST_AW-1:0] OFF_START  = 6'h04;
  localparam logic [HOST_AW-1:0] OFF_STAT   = 6'h08;
  localparam logic [HOST_AW-1:0] OFF_ADDRLO = 6'h0C;
  localparam logic [HOST_AW-1:0] OFF_ADDRHI = 6'h10;
  localparam logic [HOST_AW-1:0] OFF_WDATA  = 6'h14;
  localparam logic [HOST_AW-1:0] OFF_STRB   = 6'h18;
  localparam logic [HOST_AW-1:0] OFF_RDATA  = 6'h1C;
  localparam logic [HOST_AW-1:0] OFF_ISR    = 6'h20;
  localparam logic [HOST_AW-1:0] OFF_MASK   = 6'h24;
  localparam logic [HOST_AW-1:0] OFF_TMO    = 6'h28;

  // Configuration read/write codes 0x8..0xB are the non-posted ones.
  function automatic logic type_nonposted(input logic [3:0] t);
    return t[3:2] == 2'b10;
  endfunction

  // Only a successful completion returns real data.
  function automatic logic [REG_W-1:0] pick_rdata(input logic [2:0] code,
                                                  input logic [REG_W-1:0] d);
    return (code == CPL_OK) ? d : {REG_W{1'b1}};
  endfunction

endpackage

// File: rtl/pio_seq.sv
module pio_seq
  import pio_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_cmd,
  input  logic [3:0]       cfg_type,
  input  logic [63:0]      cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic [3:0]       cfg_strb,
  input  logic             cfg_bypass,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             req_ready,
  input  logic             rsp_valid,
  output logic             busy,
  output logic             req_valid,
  output logic [3:0]       req_type,
  output logic [63:0]      req_addr,
  output logic [REG_W-1:0] req_wdata,
  output logic [3:0]       req_strb,
  output logic             req_win_bypass,
  output logic             done,
  output logic             tmo_hit
);

  seq_state_t       state_q;
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   elapsed;
  logic [TMO_W:0]   limit_eff;
  logic             launch;
  logic             rsp_take;

  assign busy      = (state_q != S_IDLE);
  assign req_valid = (state_q == S_REQ);
  assign launch    = start_cmd && !busy;
  assign rsp_take  = (state_q == S_WAIT) && rsp_valid;
  assign elapsed   = {1'b0, cnt_q} + {{TMO_W{1'b0}}, 1'b1};
  assign limit_eff = (tmo_limit == '0) ? {{TMO_W{1'b0}}, 1'b1} : {1'b0, tmo_limit};
  assign tmo_hit   = busy && !rsp_take && (elapsed >= limit_eff);
  assign done      = rsp_take || tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q        <= S_IDLE;
      cnt_q          <= '0;
      req_type       <= '0;
      req_addr       <= '0;
      req_wdata      <= '0;
      req_strb       <= '0;
      req_win_bypass <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (launch) begin
            state_q        <= S_REQ;
            cnt_q          <= '0;
            req_type       <= cfg_type;
            req_addr       <= cfg_addr;
            req_wdata      <= cfg_wdata;
            req_strb       <= cfg_strb;
            req_win_bypass <= cfg_bypass;
          end
        end
        S_REQ: begin
          if (done) begin
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (req_ready) state_q <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (done) state_q <= S_IDLE;
          else      cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pio_cpl.sv
module pio_cpl
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic             tmo_hit,
  input  logic [2:0]       rsp_status,
  input  logic [REG_W-1:0] rsp_data,
  input  logic [3:0]       done_type,
  input  logic             isr_clr,
  input  logic             mask,
  output logic [2:0]       stat_code,
  output logic             stat_np,
  output logic [REG_W-1:0] rdata,
  output logic             isr,
  output logic             irq
);

  logic [2:0] cpl_code;

  assign cpl_code = tmo_hit ? CPL_CA : rsp_status;
  assign irq      = isr && !mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_code <= '0;
      stat_np   <= 1'b0;
      rdata     <= '0;
      isr       <= 1'b0;
    end else begin
      if (done) begin
        stat_code <= cpl_code;
        stat_np   <= type_nonposted(done_type);
        rdata     <= pick_rdata(cpl_code, rsp_data);
      end
      if (done)         isr <= 1'b1;
      else if (isr_clr) isr <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_pio_engine.sv
module cfg_pio_engine
  import pio_pkg::*;
#(
  parameter int unsigned TMO_W     = 16,
  parameter int unsigned TMO_RESET = 1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [3:0]         req_type,
  output logic [63:0]        req_addr,
  output logic [REG_W-1:0]   req_wdata,
  output logic [3:0]         req_strb,
  output logic               req_win_bypass,
  input  logic               rsp_valid,
  input  logic [2:0]         rsp_status,
  input  logic [REG_W-1:0]   rsp_data,
  output logic               pio_irq
);

  logic [3:0]       type_q;
  logic             bypass_q;
  logic [31:0]      addr_lo_q;
  logic [31:0]      addr_hi_q;
  logic [REG_W-1:0] wdata_q;
  logic [3:0]       strb_q;
  logic             mask_q;
  logic [TMO_W-1:0] tmo_q;

  logic             seq_busy;
  logic             seq_done;
  logic             seq_tmo;
  logic [2:0]       stat_code;
  logic             stat_np;
  logic [REG_W-1:0] rdata_q;
  logic             isr_q;

  logic wr_ctrl, wr_start, wr_addrlo, wr_addrhi, wr_wdata, wr_strb, wr_isr, wr_mask, wr_tmo;

  assign wr_ctrl   = host_we && (host_addr == OFF_CTRL);
  assign wr_start  = host_we && (host_addr == OFF_START);
  assign wr_addrlo = host_we && (host_addr == OFF_ADDRLO);
  assign wr_addrhi = host_we && (host_addr == OFF_ADDRHI);
  assign wr_wdata  = host_we && (host_addr == OFF_WDATA);
  assign wr_strb   = host_we && (host_addr == OFF_STRB);
  assign wr_isr    = host_we && (host_addr == OFF_ISR);
  assign wr_mask   = host_we && (host_addr == OFF_MASK);
  assign wr_tmo    = host_we && (host_addr == OFF_TMO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q    <= '0;
      bypass_q  <= 1'b0;
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      wdata_q   <= '0;
      strb_q    <= '0;
      mask_q    <= 1'b1;
      tmo_q     <= TMO_W'(TMO_RESET);
    end else begin
      if (wr_ctrl) begin
        type_q   <= host_wdata[3:0];
        bypass_q <= host_wdata[24];
      end
      if (wr_addrlo) addr_lo_q <= host_wdata;
      if (wr_addrhi) addr_hi_q <= host_wdata;
      if (wr_wdata)  wdata_q   <= host_wdata;
      if (wr_strb)   strb_q    <= host_wdata[3:0];
      if (wr_mask)   mask_q    <= host_wdata[0];
      if (wr_tmo)    tmo_q     <= host_wdata[TMO_W-1:0];
    end
  end

  pio_seq #(.TMO_W(TMO_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_cmd      (wr_start && host_wdata[0]),
    .cfg_type       (type_q),
    .cfg_addr       ({addr_hi_q, addr_lo_q}),
    .cfg_wdata      (wdata_q),
    .cfg_strb       (strb_q),
    .cfg_bypass     (bypass_q),
    .tmo_limit      (tmo_q),
    .req_ready      (req_ready),
    .rsp_valid      (rsp_valid),
    .busy           (seq_busy),
    .req_valid      (req_valid),
    .req_type       (req_type),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .req_strb       (req_strb),
    .req_win_bypass (req_win_bypass),
    .done           (seq_done),
    .tmo_hit        (seq_tmo)
  );

  pio_cpl u_cpl (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (seq_done),
    .tmo_hit    (seq_tmo),
    .rsp_status (rsp_status),
    .rsp_data   (rsp_data),
    .done_type  (req_type),
    .isr_clr    (wr_isr && host_wdata[0]),
    .mask       (mask_q),
    .stat_code  (stat_code),
    .stat_np    (stat_np),
    .rdata      (rdata_q),
    .isr        (isr_q),
    .irq        (pio_irq)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      OFF_CTRL:   host_rdata = {7'b0, bypass_q, 20'b0, type_q};
      OFF_START:  host_rdata = {31'b0, seq_busy};
      OFF_STAT:   host_rdata = {22'b0, stat_code, 6'b0, stat_np};
      OFF_ADDRLO: host_rdata = addr_lo_q;
      OFF_ADDRHI: host_rdata = addr_hi_q;
      OFF_WDATA:  host_rdata = wdata_q;
      OFF_STRB:   host_rdata = {28'b0, strb_q};
      OFF_RDATA:  host_rdata = rdata_q;
      OFF_ISR:    host_rdata = {31'b0, isr_q};
      OFF_MASK:   host_rdata = {31'b0, mask_q};
      OFF_TMO:    host_rdata = REG_W'(tmo_q);
      default:    host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pio_checker.sv
module pio_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        tmo_hit,
  input logic        isr,
  input logic        mask,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_addr,
  input logic [31:0] req_wdata,
  input logic [2:0]  rsp_status,
  input logic [31:0] rsp_data,
  input logic [2:0]  stat_code,
  input logic [31:0] rdata,
  input logic        pio_irq
);

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R2

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !done |=> req_valid && $stable(req_addr) && $stable(req_wdata)); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R5

  AST_RDATA_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done && !tmo_hit && rsp_status == 3'd0 |=> rdata == $past(rsp_data)); // R7

  AST_RDATA_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    done && (tmo_hit || rsp_status != 3'd0) |=> rdata == 32'hFFFF_FFFF); // R7

  AST_TMO_CA: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> stat_code == 3'd4); // R8

  AST_ISR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> isr); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask |-> !pio_irq); // R10

endmodule

bind cfg_pio_engine pio_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (seq_busy),
  .done       (seq_done),
  .tmo_hit    (seq_tmo),
  .isr        (isr_q),
  .mask       (mask_q),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .rsp_status (rsp_status),
  .rsp_data   (rsp_data),
  .stat_code  (stat_code),
  .rdata      (rdata_q),
  .pio_irq    (pio_irq)
);

// File: tb/tb_cfg_pio_engine.sv
`timescale 1ns/1ps
module tb_cfg_pio_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [3:0]  req_type;
  logic [63:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_strb;
  logic        req_win_bypass;
  logic        rsp_valid = 1'b0;
  logic [2:0]  rsp_status = '0;
  logic [31:0] rsp_data = '0;
  logic        pio_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfg_pio_engine dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_type(req_type), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_strb(req_strb), .req_win_bypass(req_win_bypass),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_data(rsp_data),
    .pio_irq(pio_irq)
  );

  localparam logic [5:0] A_CTRL = 6'h00, A_START = 6'h04, A_STAT = 6'h08,
    A_ALO = 6'h0C, A_AHI = 6'h10, A_WD = 6'h14, A_STRB = 6'h18,
    A_RD = 6'h1C, A_ISR = 6'h20, A_MASK = 6'h24, A_TMO = 6'h28;

  function automatic logic [31:0] cfg_addr(input int bus, input int dev,
                                           input int fn, input int regoff);
    return 32'((bus & 255) * (1 << 20) + (dev & 31) * (1 << 15) +
               (fn & 7) * (1 << 12) + (regoff & 12'hFFC));
  endfunction

  function automatic logic [3:0] strobe_of(input int size, input int off);
    return 4'(((1 << size) - 1) << off);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic handshake_and_respond(input logic [2:0] st, input logic [31:0] d);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    rsp_valid = 1'b1; rsp_status = st; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_START, v); chk("R1 start", v, 0);
    rd(A_STAT, v);  chk("R1 status", v, 0);
    rd(A_RD, v);    chk("R1 rdata", v, 0);
    rd(A_ISR, v);   chk("R1 isr", v, 0);
    rd(A_MASK, v);  chk("R1 mask", v, 1);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 irq", pio_irq, 0);
  endtask

  task automatic t_read_ok();
    logic [31:0] v;
    logic [31:0] a = cfg_addr(3, 5, 2, 16'h10);
    wr(A_CTRL, 32'h8); wr(A_ALO, a); wr(A_AHI, 0); wr(A_STRB, 32'hF);
    wr(A_START, 1);
    chk("R2 req_valid", req_valid, 1);
    chk("R2 type", req_type, 4'h8);
    chk("R2 addr", req_addr, {32'h0, a});
    chk("R2 strb", req_strb, 4'hF);
    chk("R2 bypass", req_win_bypass, 0);
    rd(A_START, v); chk("R2 start busy", v, 1);
    handshake_and_respond(3'd0, 32'h1234_5678);
    rd(A_START, v); chk("R5 start done", v, 0);
    rd(A_STAT, v);  chk("R5 R6 status ok np", v, 32'h1);
    rd(A_RD, v);    chk("R7 rdata ok", v, 32'h1234_5678);
    rd(A_ISR, v);   chk("R9 isr set", v, 1);
    chk("R10 masked irq", pio_irq, 0);
    wr(A_MASK, 0);
    chk("R10 unmasked irq", pio_irq, 1);
    wr(A_ISR, 0);
    rd(A_ISR, v);   chk("R9 write0 no effect", v, 1);
    wr(A_ISR, 1);
    rd(A_ISR, v);   chk("R9 w1c", v, 0);
    chk("R10 irq after clear", pio_irq, 0);
  endtask

  task automatic t_stray_idle();
    logic [31:0] v;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_status = 3'd1; rsp_data = 32'hDEAD_BEEF;
    @(negedge clk);
    rsp_valid = 1'b0;
    rd(A_STAT, v); chk("R11 idle status", v, 32'h1);
    rd(A_ISR, v);  chk("R11 idle isr", v, 0);
    rd(A_RD, v);   chk("R11 idle rdata", v, 32'h1234_5678);
  endtask

  task automatic t_write_ur();
    logic [31:0] v;
    logic [31:0] a = cfg_addr(1, 0, 0, 16'h4);
    wr(A_CTRL, 32'h0100_000B); wr(A_ALO, a); wr(A_AHI, 32'h5);
    wr(A_WD, 32'hABCD << (8 * 2)); wr(A_STRB, strobe_of(2, 2));
    wr(A_START, 1);
    chk("R2 write strb", req_strb, 4'hC);
    chk("R2 write data", req_wdata, 32'hABCD_0000);
    wr(A_CTRL, 32'h8); wr(A_ALO, 0); wr(A_WD, 0); wr(A_AHI, 0);
    chk("R4 type held", req_type, 4'hB);
    chk("R4 addr held", req_addr, {32'h5, a});
    chk("R4 data held", req_wdata, 32'hABCD_0000);
    chk("R4 bypass held", req_win_bypass, 1);
    wr(A_START, 1); wr(A_START, 0);
    rd(A_START, v); chk("R3 still busy", v, 1);
    chk("R3 req kept", req_valid, 1);
    handshake_and_respond(3'd1, 32'h5555_5555);
    rd(A_STAT, v); chk("R5 status ur", v, 32'h81);
    rd(A_RD, v);   chk("R7 rdata ur", v, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    chk("R3 no second request", req_valid, 0);
    wr(A_ISR, 1);
  endtask

  task automatic t_posted_crs();
    logic [31:0] v;
    wr(A_CTRL, 32'h2); wr(A_START, 1);
    rsp_valid = 1'b1; rsp_status = 3'd4; rsp_data = 0;
    @(negedge clk);
    rsp_valid = 1'b0;
    rd(A_START, v); chk("R11 pre-handshake ignored", v, 1);
    chk("R11 req still valid", req_valid, 1);
    handshake_and_respond(3'd2, 32'h0);
    rd(A_STAT, v); chk("R6 posted crs status", v, 32'h100);
    rd(A_RD, v);   chk("R7 rdata crs", v, 32'hFFFF_FFFF);
    wr(A_ISR, 1);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(A_TMO, 20); wr(A_CTRL, 32'h9); wr(A_START, 1);
    repeat (19) @(negedge clk);
    rd(A_START, v); chk("R8 busy before limit", v, 1);
    @(negedge clk);
    rd(A_START, v); chk("R8 done at limit", v, 0);
    rd(A_STAT, v);  chk("R8 status ca", v, 32'h201);
    rd(A_RD, v);    chk("R8 rdata", v, 32'hFFFF_FFFF);
    rd(A_ISR, v);   chk("R9 isr on timeout", v, 1);
    chk("R10 irq on timeout", pio_irq, 1);
    chk("R8 req dropped", req_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_stray_idle();
    t_write_ur();
    t_posted_crs();
    t_timeout();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule